// File: doc/BRIEF.md
# Serial Port with APB Register Interface and Status Interrupts

This block is a serial port that a processor reaches through an APB slave interface. Software places one byte at a time in a transmit holding register. A bit-serial transmitter sends it as a frame with one start bit, eight data bits sent LSB first, no parity and one stop bit. A bit-serial receiver samples the incoming line at the middle of each bit and puts each good frame into a one-byte receive holding register. A programmable divider sets the bit period in PCLK cycles.

Overruns on either side raise sticky flags. Four interrupt outputs (transmit done, receive ready, transmit overrun, receive overrun) and one combined output report events to the processor. Every interrupt can be cleared by writing one to it. A twelve-word read-only identification window sits at the top of the 4 KB space.

Top module: `apb_serial_port`

## Requirements
- R1: After reset, every stored register reads 0 (STAT, CFG, IRQ and DIV), `txd` idles at 1, all interrupt outputs are 0, `pready` is always 1 and `pslverr` is always 0.
- R2: The register words are at these offsets: data at 0x00, status (STAT) at 0x04, configuration (CFG) at 0x08, interrupt status (IRQ) at 0x0C and divider (DIV) at 0x10. The word at 0xFD0+4k (k = 0..11) returns byte k of parameter ID_BYTES. With the default parameters, word 0 is 0x96, word 1 is 0x03, word 8 is 0x19 and word 11 is 0xC5. Unmapped offsets read 0. Writes to the ID window and to unmapped offsets change nothing.
- R3: CFG stores only bits [6:0]. Bit 0 enables transmit, bit 1 enables receive, bit 2 enables the transmit interrupt, bit 3 enables the receive interrupt, bit 4 enables the transmit-overrun interrupt, bit 5 enables the receive-overrun interrupt and bit 6 is a stored test-mode flag.
- R4: DIV stores 20 bits. While DIV is below 16, both serial engines stay idle. Otherwise each bit lasts DIV PCLK cycles, and a frame is a 0 start bit, 8 data bits LSB first and a 1 stop bit.
- R5: A data write while STAT bit 0 (transmit full) is 1 sets STAT bit 2 (transmit overrun) and replaces the held byte. Otherwise the write sets transmit full. Transmit full clears when the transmitter takes the byte, which needs transmit enabled and a valid divider.
- R6: When the transmitter takes a byte and the transmit interrupt is enabled, IRQ bit 0 and `irq_tx` are set. Writing 1 to IRQ bit 0 clears them.
- R7: When receive is enabled, a good frame stores its byte and sets STAT bit 1 (receive full). If the receive interrupt is enabled, it also sets IRQ bit 1 and `irq_rx`. Reading the data word returns the byte and clears receive full.
- R8: IRQ bit 2 and `irq_txo` equal STAT bit 2 AND CFG bit 4. Writing 1 to IRQ bit 2 clears STAT bit 2.
- R9: A frame that arrives while receive full is 1 sets STAT bit 3 (receive overrun) and replaces the held byte. IRQ bit 3 and `irq_rxo` equal STAT bit 3 AND CFG bit 5.
- R10: Writing 1 to STAT bit 2 or bit 3 clears that bit. Writes to STAT bits 0 and 1 have no effect.
- R11: A frame that arrives while receive is disabled is dropped and leaves STAT unchanged.
- R12: A low pulse shorter than half a bit is rejected as a false start. A frame whose stop bit is read as 0 is discarded without setting receive full.
- R13: `irq_any` is the OR of the four IRQ bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and serial clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive-ready interrupt |
| irq_txo | output | 1 | Transmit-overrun interrupt |
| irq_rxo | output | 1 | Receive-overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
The hardest state to reach from the ports is transmit overrun. With a valid divider and transmit enabled, the holding register empties into the shifter one cycle after a write, so a second write almost never finds it full. The bench first programs the divider below 16 with transmit enabled, which parks the byte in the holding register. It then writes again, checks the overrun flag and its interrupt, and only then makes the divider valid to show that the replacement byte is the one sent. Receive overrun needs two complete frames with no read in between, and the framing-error path needs a frame driven with a deliberately low stop bit.

// File: rtl/serport_pkg.sv
package serport_pkg;

   localparam int unsigned OFS_DATA  = 'h000;
   localparam int unsigned OFS_STAT  = 'h004;
   localparam int unsigned OFS_CFG   = 'h008;
   localparam int unsigned OFS_IRQ   = 'h00C;
   localparam int unsigned OFS_DIV   = 'h010;
   localparam int unsigned OFS_ID_LO = 'hFD0;
   localparam int unsigned OFS_ID_HI = 'hFFC;
   localparam int unsigned CFG_W     = 7;

   // Field order fixed: last member is bit 0
   typedef struct packed {
      logic hs_test;
      logic rxo_ie;
      logic txo_ie;
      logic rx_ie;
      logic tx_ie;
      logic rx_en;
      logic tx_en;
   } cfg_t;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_HOLD
   } rx_state_t;

endpackage

// File: rtl/serport_tx.sv
module serport_tx #(
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned DIV_W     = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [DATA_BITS-1:0] byte_in,
   input  logic [DIV_W-1:0]     div,
   output logic                 take,
   output logic                 busy,
   output logic                 txd
);
   localparam int unsigned FRAME_BITS = DATA_BITS + 2;
   localparam int unsigned BITN_W     = $clog2(FRAME_BITS);
   localparam logic [BITN_W-1:0] LAST_BIT = BITN_W'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] shift_q;
   logic [DIV_W-1:0]      cnt_q;
   logic [BITN_W-1:0]     bitn_q;

   assign take = go & ~busy;
   assign txd  = shift_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '1;
         cnt_q   <= '0;
         bitn_q  <= '0;
         busy    <= 1'b0;
      end else if (take) begin
         shift_q <= {1'b1, byte_in, 1'b0};
         cnt_q   <= div - 1'b1;
         bitn_q  <= '0;
         busy    <= 1'b1;
      end else if (busy) begin
         if (cnt_q == '0) begin
            shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
            cnt_q   <= div - 1'b1;
            if (bitn_q == LAST_BIT) busy <= 1'b0;
            else                    bitn_q <= bitn_q + 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R4
   start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (txd == 1'b0));

endmodule

// File: rtl/serport_rx.sv
module serport_rx import serport_pkg::*; #(
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned DIV_W       = 20,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [DIV_W-1:0]     div,
   input  logic                 rxd,
   output logic                 valid,
   output logic [DATA_BITS-1:0] data
);
   localparam int unsigned BITN_W = $clog2(DATA_BITS);
   localparam logic [BITN_W-1:0] LAST_BIT = BITN_W'(DATA_BITS - 1);

   logic line;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], rxd} >> 0;
         end
         assign line = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_t             st_q;
   logic [DIV_W-1:0]      cnt_q;
   logic [BITN_W-1:0]     bitn_q;
   logic [DATA_BITS-1:0]  sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         cnt_q  <= '0;
         bitn_q <= '0;
         sh_q   <= '0;
         valid  <= 1'b0;
         data   <= '0;
      end else begin
         valid <= 1'b0;
         if (!en) begin
            st_q <= RX_IDLE;
         end else begin
            case (st_q)
               RX_IDLE: if (!line) begin
                  st_q  <= RX_START;
                  cnt_q <= (div >> 1) - 1'b1;
               end
               RX_START: if (cnt_q == '0) begin
                  st_q   <= line ? RX_IDLE : RX_DATA;
                  cnt_q  <= div - 1'b1;
                  bitn_q <= '0;
               end else cnt_q <= cnt_q - 1'b1;
               RX_DATA: if (cnt_q == '0) begin
                  sh_q  <= {line, sh_q[DATA_BITS-1:1]};
                  cnt_q <= div - 1'b1;
                  if (bitn_q == LAST_BIT) st_q <= RX_STOP;
                  else                    bitn_q <= bitn_q + 1'b1;
               end else cnt_q <= cnt_q - 1'b1;
               RX_STOP: if (cnt_q == '0) begin
                  if (line) begin
                     valid <= 1'b1;
                     data  <= sh_q;
                     st_q  <= RX_IDLE;
                  end else begin
                     st_q <= RX_HOLD;
                  end
               end else cnt_q <= cnt_q - 1'b1;
               RX_HOLD: if (line) st_q <= RX_IDLE;
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   // R12
   single_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

endmodule

// File: rtl/serport_regs.sv
module serport_regs import serport_pkg::*; #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned DIV_W     = 20,
   parameter int unsigned MIN_DIV   = 16,
   parameter logic [95:0] ID_BYTES  = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   input  logic                 rx_valid,
   input  logic [DATA_BITS-1:0] rx_byte,
   input  logic                 tx_take,
   output logic                 tx_go,
   output logic [DATA_BITS-1:0] tx_byte,
   output logic [DIV_W-1:0]     div,
   output logic                 div_ok,
   output logic                 rx_on,
   output logic [3:0]           irq_vec
);
   localparam int unsigned WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] W_DATA = WORD_W'(OFS_DATA >> 2);
   localparam logic [WORD_W-1:0] W_STAT = WORD_W'(OFS_STAT >> 2);
   localparam logic [WORD_W-1:0] W_CFG  = WORD_W'(OFS_CFG  >> 2);
   localparam logic [WORD_W-1:0] W_IRQ  = WORD_W'(OFS_IRQ  >> 2);
   localparam logic [WORD_W-1:0] W_DIV  = WORD_W'(OFS_DIV  >> 2);
   localparam logic [WORD_W-1:0] W_IDLO = WORD_W'(OFS_ID_LO >> 2);
   localparam logic [WORD_W-1:0] W_IDHI = WORD_W'(OFS_ID_HI >> 2);

   cfg_t                 cfg_q;
   logic [DIV_W-1:0]     div_q;
   logic [DATA_BITS-1:0] txbuf_q, rxbuf_q;
   logic                 txf_q, rxf_q, txo_q, rxo_q, itx_q, irx_q;

   logic [WORD_W-1:0] word;
   logic [3:0]        id_idx;
   logic              wr_data, wr_stat, wr_cfg, wr_irq, wr_div, rd_data;
   logic              rx_acc, clr_txo, clr_rxo;
   logic              unused_ok;

   assign word      = addr[ADDR_W-1:2];
   assign id_idx    = 4'(word - W_IDLO);
   assign wr_data   = wr_en && (word == W_DATA);
   assign wr_stat   = wr_en && (word == W_STAT);
   assign wr_cfg    = wr_en && (word == W_CFG);
   assign wr_irq    = wr_en && (word == W_IRQ);
   assign wr_div    = wr_en && (word == W_DIV);
   assign rd_data   = rd_en && (word == W_DATA);
   assign rx_acc    = rx_valid && cfg_q.rx_en;
   assign clr_txo   = (wr_stat || wr_irq) && wdata[2];
   assign clr_rxo   = (wr_stat || wr_irq) && wdata[3];
   assign unused_ok = ^{addr[1:0], wdata[31:DIV_W], cfg_q.hs_test};

   assign div     = div_q;
   assign div_ok  = (div_q >= DIV_W'(MIN_DIV));
   assign tx_go   = txf_q && cfg_q.tx_en && div_ok;
   assign tx_byte = txbuf_q;
   assign rx_on   = div_ok;
   assign irq_vec = {rxo_q & cfg_q.rxo_ie, txo_q & cfg_q.txo_ie, irx_q, itx_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         div_q   <= '0;
         txbuf_q <= '0;
         rxbuf_q <= '0;
         txf_q   <= 1'b0;
         rxf_q   <= 1'b0;
         txo_q   <= 1'b0;
         rxo_q   <= 1'b0;
         itx_q   <= 1'b0;
         irx_q   <= 1'b0;
      end else begin
         if (wr_cfg) cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
         if (wr_div) div_q <= wdata[DIV_W-1:0];
         // transmit holding register
         if (wr_data)      txbuf_q <= wdata[DATA_BITS-1:0];
         if (wr_data)      txf_q   <= 1'b1;
         else if (tx_take) txf_q   <= 1'b0;
         if (wr_data && txf_q && !tx_take) txo_q <= 1'b1;
         else if (clr_txo)                 txo_q <= 1'b0;
         if (tx_take && cfg_q.tx_ie)       itx_q <= 1'b1;
         else if (wr_irq && wdata[0])      itx_q <= 1'b0;
         // receive holding register
         if (rx_acc)       rxbuf_q <= rx_byte;
         if (rx_acc)       rxf_q   <= 1'b1;
         else if (rd_data) rxf_q   <= 1'b0;
         if (rx_acc && rxf_q && !rd_data) rxo_q <= 1'b1;
         else if (clr_rxo)                rxo_q <= 1'b0;
         if (rx_acc && cfg_q.rx_ie)       irx_q <= 1'b1;
         else if (wr_irq && wdata[1])     irx_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (word == W_DATA)      rdata = 32'(rxbuf_q);
      else if (word == W_STAT) rdata = {28'b0, rxo_q, txo_q, rxf_q, txf_q};
      else if (word == W_CFG)  rdata = 32'(cfg_q);
      else if (word == W_IRQ)  rdata = {28'b0, irq_vec};
      else if (word == W_DIV)  rdata = 32'(div_q);
      else if (word >= W_IDLO && word <= W_IDHI)
         rdata = {24'b0, 8'(ID_BYTES >> (8 * int'(id_idx)))};
   end

   // R5
   txf_clears_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txf_q) |-> $past(tx_take));

   // R9
   rxo_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxo_q) |-> $past(rxf_q));

   // R7
   read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_valid) |=> !rxf_q);

   // R4
   idle_when_div_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_ok |-> !tx_take);

endmodule

// File: rtl/apb_serial_port.sv
module apb_serial_port #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned DIV_W       = 20,
   parameter int unsigned MIN_DIV     = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [95:0] ID_BYTES    = 96'hC5_00_72_19_00_00_00_00_00_00_03_96
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic              rxd,
   output logic              txd,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_txo,
   output logic              irq_rxo,
   output logic              irq_any
);
   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must cover the identification window");
      end
      if (DIV_W < 5 || DIV_W > 32) begin : g_bad_div
         $error("DIV_W out of range");
      end
      if (DATA_BITS < 5 || DATA_BITS > 8) begin : g_bad_data
         $error("DATA_BITS out of range");
      end
   endgenerate

   logic                 wr_en, rd_en;
   logic                 rx_valid, tx_take, tx_go, tx_busy, div_ok, rx_on;
   logic [DATA_BITS-1:0] rx_byte, tx_byte;
   logic [DIV_W-1:0]     div;
   logic [3:0]           irq_vec;

   assign wr_en   = psel && penable && pwrite;
   assign rd_en   = psel && penable && !pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;
   assign irq_tx  = irq_vec[0];
   assign irq_rx  = irq_vec[1];
   assign irq_txo = irq_vec[2];
   assign irq_rxo = irq_vec[3];
   assign irq_any = |irq_vec;

   serport_regs #(
      .ADDR_W(ADDR_W), .DATA_BITS(DATA_BITS), .DIV_W(DIV_W),
      .MIN_DIV(MIN_DIV), .ID_BYTES(ID_BYTES)
   ) regs_i (
      .clk(pclk), .rst_n(presetn), .wr_en(wr_en), .rd_en(rd_en),
      .addr(paddr), .wdata(pwdata), .rdata(prdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_take(tx_take),
      .tx_go(tx_go), .tx_byte(tx_byte), .div(div), .div_ok(div_ok),
      .rx_on(rx_on), .irq_vec(irq_vec)
   );

   serport_tx #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) tx_i (
      .clk(pclk), .rst_n(presetn), .go(tx_go), .byte_in(tx_byte),
      .div(div), .take(tx_take), .busy(tx_busy), .txd(txd)
   );

   serport_rx #(
      .DATA_BITS(DATA_BITS), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
   ) rx_i (
      .clk(pclk), .rst_n(presetn), .en(rx_on), .div(div), .rxd(rxd),
      .valid(rx_valid), .data(rx_byte)
   );

   // R13
   any_matches_vec_chk: assert property (@(posedge pclk) disable iff (!presetn)
      $rose(irq_any) |-> (irq_tx || irq_rx || irq_txo || irq_rxo));

   // R1
   tx_idle_high_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !tx_busy |-> txd);

endmodule

// File: tb/apb_serial_port_tb.sv
module apb_serial_port_tb_top;
   localparam int DIVV = 16;

   logic        clk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, rxd = 1'b1, txd;
   logic        irq_tx, irq_rx, irq_txo, irq_rxo, irq_any;
   int          n_cmp = 0, n_err = 0;

   always #4 clk = ~clk;

   apb_serial_port dut_i (
      .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .rxd(rxd), .txd(txd),
      .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txo(irq_txo),
      .irq_rxo(irq_rxo), .irq_any(irq_any)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(posedge clk); #1;
      penable = 1'b1;
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(posedge clk); #1;
      penable = 1'b1;
      #2 d = prdata;
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic send(input logic [7:0] b, input logic stopv);
      @(posedge clk); #1 rxd = 1'b0;
      repeat (DIVV) @(posedge clk);
      for (int i = 0; i < 8; i++) begin
         #1 rxd = b[i];
         repeat (DIVV) @(posedge clk);
      end
      #1 rxd = stopv;
      repeat (DIVV) @(posedge clk);
      #1 rxd = 1'b1;
      repeat (2 * DIVV) @(posedge clk);
   endtask

   task automatic capture(output logic [7:0] b, output logic ok);
      int n = 0;
      ok = 1'b1;
      b = '0;
      while (txd !== 1'b0 && n < 2000) begin
         @(negedge clk); n++;
      end
      if (n >= 2000) ok = 1'b0;
      repeat (DIVV / 2) @(negedge clk);
      if (txd !== 1'b0) ok = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (DIVV) @(negedge clk);
         b[i] = txd;
      end
      repeat (DIVV) @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
   endtask

   task automatic t_reset;
      rd_chk("R1 stat", 12'h004, 32'h0);
      rd_chk("R1 cfg", 12'h008, 32'h0);
      rd_chk("R1 irq", 12'h00C, 32'h0);
      rd_chk("R1 div", 12'h010, 32'h0);
      chk("R1 txd idle", 32'(txd), 32'h1);
      chk("R1 irq lines", {27'b0, irq_any, irq_rxo, irq_txo, irq_rx, irq_tx}, 32'h0);
      chk("R1 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
   endtask

   task automatic t_map;
      rd_chk("R2 id0", 12'hFD0, 32'h96);
      rd_chk("R2 id1", 12'hFD4, 32'h03);
      rd_chk("R2 id8", 12'hFF0, 32'h19);
      rd_chk("R2 id11", 12'hFFC, 32'hC5);
      rd_chk("R2 unmapped", 12'h014, 32'h0);
      wr(12'hFD0, 32'hFFFF_FFFF);
      wr(12'h014, 32'hFFFF_FFFF);
      rd_chk("R2 id write ignored", 12'hFD0, 32'h96);
      rd_chk("R2 unmapped write ignored", 12'h014, 32'h0);
      rd_chk("R2 cfg untouched", 12'h008, 32'h0);
   endtask

   task automatic t_cfg_div;
      wr(12'h008, 32'hFFFF_FF80);
      rd_chk("R3 high bits dropped", 12'h008, 32'h0);
      wr(12'h008, 32'h0000_0040);
      rd_chk("R3 test flag stored", 12'h008, 32'h40);
      wr(12'h010, 32'hFFFF_FFFF);
      rd_chk("R4 div 20 bits", 12'h010, 32'h000F_FFFF);
      wr(12'h010, 32'd8);
   endtask

   task automatic t_tx_overrun;
      logic [7:0] b;
      logic       ok;
      wr(12'h008, 32'h15);               // tx_en, tx_ie, txo_ie
      wr(12'h000, 32'hC3);
      repeat (40) @(posedge clk);
      #1 chk("R4 idle with bad div", 32'(txd), 32'h1);
      rd_chk("R5 tx full held", 12'h004, 32'h1);
      wr(12'h000, 32'h3C);
      rd_chk("R5 overrun set", 12'h004, 32'h5);
      rd_chk("R8 irq txo bit", 12'h00C, 32'h4);
      chk("R8 irq_txo line", {30'b0, irq_txo, irq_any}, 32'h3);
      wr(12'h004, 32'h3);
      rd_chk("R10 ro bits kept", 12'h004, 32'h5);
      wr(12'h00C, 32'h4);
      rd_chk("R8 irq clear clears stat", 12'h004, 32'h1);
      chk("R13 any low", 32'(irq_any), 32'h0);
      wr(12'h010, DIVV);
      capture(b, ok);
      chk("R4 frame ok", 32'(ok), 32'h1);
      chk("R5 replaced byte sent", 32'(b), 32'h3C);
      rd_chk("R5 full cleared", 12'h004, 32'h0);
      rd_chk("R6 tx irq", 12'h00C, 32'h1);
      chk("R6 irq_tx line", {30'b0, irq_tx, irq_any}, 32'h3);
      wr(12'h00C, 32'h1);
      chk("R6 cleared", {30'b0, irq_tx, irq_any}, 32'h0);
      wr(12'h000, 32'h81);
      capture(b, ok);
      chk("R4 second frame ok", 32'(ok), 32'h1);
      chk("R4 second byte", 32'(b), 32'h81);
      wr(12'h00C, 32'h1);
   endtask

   task automatic t_rx;
      wr(12'h008, 32'h2A);               // rx_en, rx_ie, rxo_ie
      send(8'hA5, 1'b1);
      rd_chk("R7 rx full", 12'h004, 32'h2);
      chk("R7 irq_rx", {30'b0, irq_rx, irq_any}, 32'h3);
      rd_chk("R7 data", 12'h000, 32'hA5);
      rd_chk("R7 read clears full", 12'h004, 32'h0);
      wr(12'h00C, 32'h2);
      chk("R7 irq cleared", 32'(irq_rx), 32'h0);
      send(8'h11, 1'b1);
      send(8'h7E, 1'b1);
      rd_chk("R9 overrun", 12'h004, 32'hA);
      rd_chk("R9 irq bits", 12'h00C, 32'hA);
      chk("R9 irq_rxo", 32'(irq_rxo), 32'h1);
      rd_chk("R9 newest byte", 12'h000, 32'h7E);
      wr(12'h004, 32'h8);
      rd_chk("R10 w1c rxo", 12'h004, 32'h0);
      wr(12'h00C, 32'h2);
      chk("R13 any low after clear", 32'(irq_any), 32'h0);
   endtask

   task automatic t_rx_drop_err;
      wr(12'h008, 32'h08);
      send(8'h55, 1'b1);
      rd_chk("R11 dropped", 12'h004, 32'h0);
      wr(12'h008, 32'h2A);
      send(8'h66, 1'b0);
      rd_chk("R12 bad stop discarded", 12'h004, 32'h0);
      @(posedge clk); #1 rxd = 1'b0;
      repeat (3) @(posedge clk);
      #1 rxd = 1'b1;
      repeat (4 * DIVV) @(posedge clk);
      rd_chk("R12 glitch rejected", 12'h004, 32'h0);
      send(8'h99, 1'b1);
      rd_chk("R12 recovers", 12'h000, 32'h99);
      chk("R13 any with rx", 32'(irq_any), 32'h1);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 presetn = 1'b1;
      t_reset();
      t_map();
      t_cfg_div();
      t_tx_overrun();
      t_rx();
      t_rx_drop_err();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

endmodule